// File: doc/BRIEF.md
# System Reset Arbiter with Watchdog and Supply Filter

This block produces the single system reset for a small 8-bit controller. Three sources can pull it: an active-low external reset pin, a digital low-supply flag from an analog comparator, and a watchdog that counts system clocks and fires when software stops reloading it. The pin and the comparator flags are asynchronous and are brought into the clock domain through two-flop synchronisers. The low-supply flag must persist for a programmable number of clocks before it causes a reset. A second comparator flag, supply-recovered, releases that reset, which gives hysteresis.

When the watchdog expires, or a low-supply reset begins, the block drives its own reset pin low for a fixed number of clocks so that the event can be seen on the board. The block must not mistake that self-inflicted low for an external reset, so pin sensing is blanked during the pulse and for two clocks after it. A control byte enables the watchdog. A cause register records which sources have triggered and is cleared by writing ones.

Top module: `sysrst_ctrl`

## Requirements
- R1: `sys_rst_n_o` is low whenever any source is active. It goes low on the first clock edge at which the registered source is active: the filtered low-supply hold, the pin-pulse counter, or the synchronised external pin.
- R2: The external pin `rst_pin_n_i` is active low and passes through two flops. A low pin that is not blanked pulls `sys_rst_n_o` low three clock edges later and holds it low while the pin stays low.
- R3: Bit 5 of the control byte (`ctl_rdata_o[5]`) enables the watchdog. While the bit is 0 the watchdog count stays at zero and never fires. The control byte is cleared to 0x00 while system reset is active, and writes made during reset are dropped.
- R4: With the watchdog enabled and no reload, the watchdog fires after `WDT_INTERVAL` clocks. A one-cycle `wdt_kick_i` restarts the count.
- R5: A watchdog expiry, or the start of a low-supply reset, raises `pin_pull_o` for exactly `PULL_LEN` clocks. System reset is held for the whole pulse and released on the same edge that ends it.
- R6: A low-supply reset starts only when the synchronised `supply_low_i` has been high for `LOW_WIN`+1 consecutive clocks. A shorter high period has no effect.
- R7: Once started, the low-supply reset is held until the synchronised `supply_ok_i` is 1 and `supply_low_i` is 0.
- R8: The external pin is ignored while `pin_pull_o` is high and for two clocks after it falls, so the block's own pulse never records an external cause.
- R9: The cause register `cause_o` uses bit 0 for external, bit 1 for low-supply and bit 2 for watchdog. A bit is set when its source starts a reset. Writing 1s through `cause_clr_i` with `cause_clr_we_i` clears those bits, a write of zeros leaves the register unchanged, and a new set wins over a clear in the same cycle.
- R10: `por_n` clears all state asynchronously. During power-on reset `sys_rst_n_o` is low, `pin_pull_o` is low, and the control and cause registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset for the block, active low |
| rst_pin_n_i | input | 1 | Sensed level of the external reset pin, active low, asynchronous |
| supply_low_i | input | 1 | Comparator flag: supply below trip level, asynchronous |
| supply_ok_i | input | 1 | Comparator flag: supply above release level, asynchronous |
| ctl_we_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte write data (bit 5 = watchdog enable) |
| wdt_kick_i | input | 1 | One-cycle watchdog reload strobe |
| cause_clr_we_i | input | 1 | Cause register write-one-to-clear strobe |
| cause_clr_i | input | 3 | Cause bits to clear |
| ctl_rdata_o | output | 8 | Current control byte |
| cause_o | output | 3 | Reset cause bits {watchdog, low-supply, external} |
| sys_rst_n_o | output | 1 | Internal system reset, active low |
| pin_pull_o | output | 1 | Open-drain enable: 1 drives the reset pin low |

## Verification
The hardest state to reach is the end of the block's own pin pulse. The pin climbs back through the synchroniser, and only the two-clock blanking tail stops the block from re-arming itself on its own low. The bench wires the pin as an open-drain net, the external driver ANDed with `pin_pull_o` inverted, so every watchdog and low-supply pulse really loops back into the pin input. It then lets the watchdog starve and holds the supply flag across the persistence boundary (one clock short, then exactly long enough), so that this loop-back is exercised again and again against a per-cycle reference model.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
    localparam int CAUSE_W    = 3;
    localparam int CAUSE_EXT  = 0;
    localparam int CAUSE_LVD  = 1;
    localparam int CAUSE_WDT  = 2;
    localparam int CTL_W      = 8;
    localparam int CTL_WDT_EN = 5;
    localparam int MASK_TAIL  = 2;
    localparam int SYNC_W     = 3;
    localparam int SYN_PIN    = 0;
    localparam int SYN_LOW    = 1;
    localparam int SYN_OK     = 2;

    typedef logic [CAUSE_W-1:0] cause_t;
    typedef logic [CTL_W-1:0]   ctl_t;
endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
    parameter int           W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{s1: INIT, s2: INIT};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/sysrst_supply_filter.sv
module sysrst_supply_filter #(
    parameter int LOW_WIN = 400
) (
    input  logic clk,
    input  logic por_n,
    input  logic low_i,
    input  logic ok_i,
    output logic hold_o,
    output logic hold_next_o
);
    localparam int             CW    = $clog2(LOW_WIN + 1);
    localparam logic [CW-1:0]  WIN_C = CW'(LOW_WIN);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hold;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (low_i) begin
            if (st_q.cnt != WIN_C) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
        if (st_q.hold) begin
            if (ok_i && !low_i) begin
                st_d.hold = 1'b0;
            end
        end else if (low_i && (st_q.cnt == WIN_C)) begin
            st_d.hold = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o      = st_q.hold;
    assign hold_next_o = st_d.hold;

    // R7
    hold_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (hold_o && !(ok_i && !low_i)) |=> hold_o);

    // R6
    hold_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(hold_o) |-> $past(low_i));
endmodule

// File: rtl/sysrst_wdog.sv
module sysrst_wdog #(
    parameter int INTERVAL = 16384
) (
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst_i,
    input  logic en_i,
    input  logic kick_i,
    output logic fire_o
);
    localparam int            CW   = $clog2(INTERVAL);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } wd_st_t;

    wd_st_t st_d, st_q;
    logic   fire;

    always_comb begin
        st_d = st_q;
        fire = en_i && !sys_rst_i && !kick_i && (st_q.cnt == LAST);
        if (sys_rst_i || !en_i || kick_i || fire) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_o = fire;

    // R3
    wd_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
        !en_i |=> (st_q.cnt == '0));

    // R4
    wd_kick_chk: assert property (@(posedge clk) disable iff (!por_n)
        kick_i |=> (st_q.cnt == '0));
endmodule

// File: rtl/sysrst_pin_pulse.sv
module sysrst_pin_pulse #(
    parameter int PULL_LEN = 60,
    parameter int TAIL     = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic trig_i,
    output logic pull_o,
    output logic mask_o,
    output logic busy_next_o
);
    localparam int            PW    = $clog2(PULL_LEN + 1);
    localparam int            TW    = $clog2(TAIL + 1);
    localparam logic [PW-1:0] LEN_C = PW'(PULL_LEN);
    localparam logic [TW-1:0] TAI_C = TW'(TAIL);

    typedef struct packed {
        logic [PW-1:0] pcnt;
        logic [TW-1:0] tcnt;
    } pulse_st_t;

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig_i) begin
            st_d.pcnt = LEN_C;
        end else if (st_q.pcnt != '0) begin
            st_d.pcnt = st_q.pcnt - 1'b1;
        end
        if ((st_q.pcnt != '0) && (st_d.pcnt == '0)) begin
            st_d.tcnt = TAI_C;
        end else if (st_q.tcnt != '0) begin
            st_d.tcnt = st_q.tcnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pull_o      = (st_q.pcnt != '0);
    assign mask_o      = pull_o || (st_q.tcnt != '0);
    assign busy_next_o = (st_d.pcnt != '0);

    // R8
    tail_mask_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(pull_o) |-> mask_o);

    // R5
    trig_load_chk: assert property (@(posedge clk) disable iff (!por_n)
        trig_i |=> pull_o);
endmodule

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl
    import sysrst_pkg::*;
#(
    parameter int WDT_INTERVAL = 16384,
    parameter int LOW_WIN      = 400,
    parameter int PULL_LEN     = 60
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_pin_n_i,
    input  logic               supply_low_i,
    input  logic               supply_ok_i,
    input  logic               ctl_we_i,
    input  logic [CTL_W-1:0]   ctl_wdata_i,
    input  logic               wdt_kick_i,
    input  logic               cause_clr_we_i,
    input  logic [CAUSE_W-1:0] cause_clr_i,
    output logic [CTL_W-1:0]   ctl_rdata_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               sys_rst_n_o,
    output logic               pin_pull_o
);
    localparam logic [SYNC_W-1:0] SYNC_INIT = SYNC_W'(3'b101);

    typedef struct packed {
        ctl_t   ctl;
        cause_t cause;
        logic   rst;
    } top_st_t;

    top_st_t            st_d, st_q;
    logic [SYNC_W-1:0]  raw_in, syn;
    logic               hold_q, hold_next, lvd_rise;
    logic               wd_fire, pulse_mask, pulse_busy_next, pull;
    logic               ext_req;

    assign raw_in = {supply_ok_i, supply_low_i, rst_pin_n_i};

    sysrst_sync #(.W(SYNC_W), .INIT(SYNC_INIT)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d_i   (raw_in),
        .q_o   (syn)
    );

    sysrst_supply_filter #(.LOW_WIN(LOW_WIN)) u_filt (
        .clk         (clk),
        .por_n       (por_n),
        .low_i       (syn[SYN_LOW]),
        .ok_i        (syn[SYN_OK]),
        .hold_o      (hold_q),
        .hold_next_o (hold_next)
    );

    sysrst_wdog #(.INTERVAL(WDT_INTERVAL)) u_wdog (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_i (st_q.rst),
        .en_i      (st_q.ctl[CTL_WDT_EN]),
        .kick_i    (wdt_kick_i),
        .fire_o    (wd_fire)
    );

    assign lvd_rise = hold_next && !hold_q;

    sysrst_pin_pulse #(.PULL_LEN(PULL_LEN), .TAIL(MASK_TAIL)) u_pulse (
        .clk         (clk),
        .por_n       (por_n),
        .trig_i      (wd_fire || lvd_rise),
        .pull_o      (pull),
        .mask_o      (pulse_mask),
        .busy_next_o (pulse_busy_next)
    );

    assign ext_req = !syn[SYN_PIN] && !pulse_mask;

    always_comb begin
        st_d     = st_q;
        st_d.rst = ext_req || hold_next || pulse_busy_next;
        if (st_q.rst) begin
            st_d.ctl = '0;
        end else if (ctl_we_i) begin
            st_d.ctl = ctl_wdata_i;
        end
        if (cause_clr_we_i) begin
            st_d.cause = st_q.cause & ~cause_clr_i;
        end
        if (ext_req && !st_q.rst) begin
            st_d.cause[CAUSE_EXT] = 1'b1;
        end
        if (lvd_rise) begin
            st_d.cause[CAUSE_LVD] = 1'b1;
        end
        if (wd_fire) begin
            st_d.cause[CAUSE_WDT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{ctl: '0, cause: '0, rst: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_rdata_o = st_q.ctl;
    assign cause_o     = st_q.cause;
    assign sys_rst_n_o = !st_q.rst;
    assign pin_pull_o  = pull;

    // R1
    lvd_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
        hold_q |-> !sys_rst_n_o);

    // R5
    pull_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
        pin_pull_o |-> !sys_rst_n_o);

    // R3
    wd_off_chk: assert property (@(posedge clk) disable iff (!por_n)
        !ctl_rdata_o[CTL_WDT_EN] |-> !wd_fire);

    // R9
    cause_wdt_chk: assert property (@(posedge clk) disable iff (!por_n)
        wd_fire |=> cause_o[CAUSE_WDT]);

    // R8
    no_self_ext_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(cause_o[CAUSE_EXT]) |-> !$past(pin_pull_o));
endmodule

// File: tb/tb_sysrst_ctrl.sv
module tb_sysrst_ctrl;
    localparam int WDI = 64;
    localparam int WIN = 20;
    localparam int PL  = 60;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       drv_n = 1'b1;
    logic       low = 1'b0;
    logic       ok = 1'b1;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic       kick = 1'b0;
    logic       clr_we = 1'b0;
    logic [2:0] clr = '0;
    logic [7:0] ctl_rd;
    logic [2:0] cause;
    logic       srst_n, pull;
    logic       pin;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign pin = drv_n & ~pull;

    sysrst_ctrl #(.WDT_INTERVAL(WDI), .LOW_WIN(WIN), .PULL_LEN(PL)) dut (
        .clk            (clk),
        .por_n          (por_n),
        .rst_pin_n_i    (pin),
        .supply_low_i   (low),
        .supply_ok_i    (ok),
        .ctl_we_i       (we),
        .ctl_wdata_i    (wdata),
        .wdt_kick_i     (kick),
        .cause_clr_we_i (clr_we),
        .cause_clr_i    (clr),
        .ctl_rdata_o    (ctl_rd),
        .cause_o        (cause),
        .sys_rst_n_o    (srst_n),
        .pin_pull_o     (pull)
    );

    // behavioural reference state
    int m_e1, m_e2, m_l1, m_l2, m_o1, m_o2;
    int m_lcnt, m_hold, m_wcnt, m_pcnt, m_mcnt, m_ctl, m_cause, m_rst;

    always @(posedge clk or negedge por_n) begin : model
        int mpin, xreq, nh, wf, lf, np, nm, nc;
        if (!por_n) begin
            m_e1 = 1; m_e2 = 1; m_l1 = 0; m_l2 = 0; m_o1 = 1; m_o2 = 1;
            m_lcnt = 0; m_hold = 0; m_wcnt = 0; m_pcnt = 0; m_mcnt = 0;
            m_ctl = 0; m_cause = 0; m_rst = 1;
        end else begin
            mpin = (drv_n && m_pcnt == 0) ? 1 : 0;
            xreq = (m_e2 == 0 && m_pcnt == 0 && m_mcnt == 0) ? 1 : 0;
            if (m_hold != 0) nh = (m_o2 != 0 && m_l2 == 0) ? 0 : 1;
            else             nh = (m_l2 != 0 && m_lcnt >= WIN) ? 1 : 0;
            wf = (m_ctl[5] && m_rst == 0 && !kick && m_wcnt == WDI - 1) ? 1 : 0;
            lf = (nh != 0 && m_hold == 0) ? 1 : 0;
            np = (wf != 0 || lf != 0) ? PL : (m_pcnt > 0 ? m_pcnt - 1 : 0);
            nm = (m_pcnt != 0 && np == 0) ? 2 : (m_mcnt > 0 ? m_mcnt - 1 : 0);
            nc = m_cause & ~(clr_we ? int'(clr) : 0);
            nc = nc | (wf << 2) | (lf << 1) | ((xreq != 0 && m_rst == 0) ? 1 : 0);
            m_lcnt = (m_l2 != 0) ? ((m_lcnt < WIN) ? m_lcnt + 1 : WIN) : 0;
            m_wcnt = (m_rst != 0 || !m_ctl[5] || kick || wf != 0) ? 0 : m_wcnt + 1;
            m_ctl  = (m_rst != 0) ? 0 : (we ? int'(wdata) : m_ctl);
            m_rst  = (xreq != 0 || nh != 0 || np != 0) ? 1 : 0;
            m_hold = nh; m_pcnt = np; m_mcnt = nm; m_cause = nc;
            m_e2 = m_e1; m_e1 = mpin;
            m_l2 = m_l1; m_l1 = int'(low);
            m_o2 = m_o1; m_o1 = int'(ok);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        chk("R1 sys_rst_n", int'(srst_n), (m_rst != 0) ? 0 : 1);
        chk("R5 pin_pull", int'(pull), (m_pcnt != 0) ? 1 : 0);
        chk("R9 cause", int'(cause), m_cause);
        chk("R3 ctl", int'(ctl_rd), m_ctl);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); we = 1'b1; wdata = v;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic wr_clr(input logic [2:0] v);
        @(negedge clk); clr_we = 1'b1; clr = v;
        @(negedge clk); clr_we = 1'b0;
    endtask

    task automatic pulse_kick();
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : main
        int lowcnt;
        int plen;
        // R10 power-on state
        cyc(3);
        chk("R10 rst during por", int'(srst_n), 0);
        chk("R10 pull during por", int'(pull), 0);
        chk("R10 cause during por", int'(cause), 0);
        chk("R10 ctl during por", int'(ctl_rd), 0);
        por_n = 1'b1;
        cyc(3);
        chk("R10 released", int'(srst_n), 1);

        // R2 external pin
        @(negedge clk); drv_n = 1'b0;
        cyc(2);
        chk("R2 not yet", int'(srst_n), 1);
        cyc(1);
        chk("R2 asserted", int'(srst_n), 0);
        cyc(5);
        chk("R2 held", int'(srst_n), 0);
        chk("R9 ext cause", int'(cause), 1);
        drv_n = 1'b1;
        cyc(5);
        chk("R2 released", int'(srst_n), 1);
        wr_clr(3'b000);
        chk("R9 zero clear keeps", int'(cause), 1);
        wr_clr(3'b001);
        chk("R9 w1c clears", int'(cause), 0);

        // R3 disabled watchdog never fires
        lowcnt = 0;
        repeat (3 * WDI) begin
            @(negedge clk);
            if (!srst_n) lowcnt++;
        end
        chk("R3 disabled no reset", lowcnt, 0);

        // R4 enabled with reloads
        wr_ctl(8'h20);
        chk("R3 enable readback", int'(ctl_rd), 32);
        lowcnt = 0;
        for (int i = 0; i < 8; i++) begin
            cyc(WDI / 2);
            pulse_kick();
            if (!srst_n) lowcnt++;
        end
        chk("R4 kicked no reset", lowcnt, 0);

        // R4/R5 starve the watchdog
        plen = 0;
        begin
            int waited = 0;
            while (!pull && waited < 4 * WDI) begin
                @(negedge clk); waited++;
            end
            chk("R4 expiry seen", (waited <= WDI + 2) ? 1 : 0, 1);
        end
        while (pull) begin
            plen++;
            chk("R5 rst during pull", int'(srst_n), 0);
            @(negedge clk);
        end
        chk("R5 pull length", plen, PL);
        chk("R5 released with pull", int'(srst_n), 1);
        cyc(6);
        chk("R8 no self ext", int'(cause), 4);
        chk("R8 stays out of reset", int'(srst_n), 1);
        chk("R3 cleared by reset", int'(ctl_rd), 0);
        wr_clr(3'b100);

        // R3 write during reset is dropped
        @(negedge clk); drv_n = 1'b0;
        cyc(5);
        wr_ctl(8'h20);
        drv_n = 1'b1;
        cyc(5);
        chk("R3 write in reset dropped", int'(ctl_rd), 0);
        wr_clr(3'b111);

        // R6 boundary: WIN cycles no effect, WIN+1 fires
        @(negedge clk); low = 1'b1;
        cyc(WIN);
        low = 1'b0;
        cyc(6);
        chk("R6 short low ignored rst", int'(srst_n), 1);
        chk("R6 short low ignored cause", int'(cause), 0);
        @(negedge clk); low = 1'b1;
        cyc(WIN + 1);
        low = 1'b0;
        cyc(4);
        chk("R6 long low fires", int'(cause), 2);
        cyc(PL + 5);
        chk("R6 recovered", int'(srst_n), 1);
        wr_clr(3'b010);

        // R7 hysteresis
        @(negedge clk); ok = 1'b0; low = 1'b1;
        cyc(WIN + 10);
        low = 1'b0;
        cyc(PL + 20);
        chk("R7 held without ok", int'(srst_n), 0);
        chk("R7 cause", int'(cause), 2);
        ok = 1'b1;
        cyc(5);
        chk("R7 released on ok", int'(srst_n), 1);
        wr_clr(3'b010);
        chk("R9 final clear", int'(cause), 0);

        cyc(5);
        summary();
        $finish;
    end
endmodule